// File: doc/BRIEF.md
# Glitch-Free Peripheral Clock Selector

This block picks the clock for one peripheral from six free-running sources: a crystal reference, two internal synthesized clocks, a debug observation clock, an external pin clock and an external video clock input. A small control register, written and read on a bus clock, holds the choice. A two-bit source field chooses among the crystal, a pre-selected internal clock and the pin clock. A second two-bit field makes the internal pre-selection. A direction bit puts the block in input mode, where the video input is used whatever the other fields say. An enable bit stops the output clock.

Every change of source is made without glitches. The current source is gated off on its own falling edge once the change has been synchronized into its domain. The new source is gated on, also on its own falling edge, only after the old gate is seen low. While the switch is in progress a read-only busy flag in the register reads 1. From reset until the first write the crystal clock is forced onto the output, whatever the fields hold.

Top module: `clksel_top`

## Requirements
- R1: After reset the register fields read en=1, source=00, pre=00, dir=1 (rd_data[5:0]=6'b100001). The crystal clock drives clk_out until the register is written for the first time, even though dir=1.
- R2: Register layout: bit0 en, bits2:1 source field, bits4:3 pre field, bit5 dir, bit6 busy (read-only), bit7 reserved. Two cycles after a write, rd_data[5:0] returns the written bits. Bit 7 always reads 0, even when it was written as 1.
- R3: With dir=0 and en=1, source 00 gives the crystal clock and source 11 gives the pin clock.
- R4: With dir=0, en=1 and source 01 or 10, the pre field selects the output: 00 gives internal clock A, 10 gives internal clock B, 11 gives the observation clock. 01 selects nothing and clk_out stays low.
- R5: With dir=1 and en=1, clk_out follows the video clock input for every value of the source and pre fields.
- R6: With en=0 (after the first write), clk_out is held low.
- R7: In the second bus cycle after a write that changes the selected source, busy (bit 6) reads 1. Once the new source is running, busy returns to 0.
- R8: At most one source gate is open at any time. During a switch no high or low pulse on clk_out is shorter than half the period of the faster of the two clocks involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of every source |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Registered register read data |
| clk_xtal | input | 1 | Crystal reference clock |
| clk_src_a | input | 1 | Internal synthesized clock A |
| clk_src_b | input | 1 | Internal synthesized clock B |
| clk_obs | input | 1 | Debug observation clock |
| clk_pin | input | 1 | External pin clock |
| clk_vid | input | 1 | External video clock input |
| clk_out | output | 1 | Selected, gated peripheral clock |

## Verification
The gate-exclusion and busy-flag properties assume two things: every source clock runs freely, and the register is not rewritten while a switch is still in progress. A quick second write could leave two synchronizer chains carrying requests at once. The stimulus therefore polls busy until it clears before each write. It also keeps reset asserted for longer than two periods of the slowest source, so every lane leaves reset with its gate closed. The sweep covers all 64 combinations of the four fields, with the reserved bit set on alternate writes.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
  localparam int NSRC     = 6;
  localparam int SRC_XTAL = 0;
  localparam int SRC_A    = 1;
  localparam int SRC_B    = 2;
  localparam int SRC_OBS  = 3;
  localparam int SRC_PIN  = 4;
  localparam int SRC_VID  = 5;

  // field order matches the register layout from bit 5 down to bit 0
  typedef struct packed {
    logic       dir;
    logic [1:0] pre;
    logic [1:0] src;
    logic       en;
  } ctl_t;

  localparam int CW = $bits(ctl_t);

  function automatic logic [NSRC-1:0] pick(input logic written, input ctl_t c);
    logic [NSRC-1:0] m;
    m = '0;
    if (!written) begin
      m[SRC_XTAL] = 1'b1;
    end else if (c.en) begin
      if (c.dir) begin
        m[SRC_VID] = 1'b1;
      end else begin
        case (c.src)
          2'b00: m[SRC_XTAL] = 1'b1;
          2'b11: m[SRC_PIN]  = 1'b1;
          default: begin
            case (c.pre)
              2'b00:   m[SRC_A]   = 1'b1;
              2'b10:   m[SRC_B]   = 1'b1;
              2'b11:   m[SRC_OBS] = 1'b1;
              default: m          = '0;
            endcase
          end
        endcase
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
module clksel_sync #(
  parameter int W     = 6,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
    end else begin
      stage[0] <= d;
      for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/clksel_lane.sv
`timescale 1ns/1ps
module clksel_lane #(
  parameter int DEPTH = 2
) (
  input  logic src_clk,
  input  logic rst,
  input  logic req,
  output logic gate
);
  logic [DEPTH-1:0] chain;

  always_ff @(posedge src_clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[DEPTH-2:0], req};
  end

  // gate moves only while the source is low, so the AND cannot slice a pulse
  always_ff @(negedge src_clk) begin
    if (rst) gate <= 1'b0;
    else     gate <= chain[DEPTH-1];
  end
endmodule

// File: rtl/clksel_regs.sv
`timescale 1ns/1ps
module clksel_regs
  import clksel_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            busy,
  output logic [DW-1:0]   rd_data,
  output logic [NSRC-1:0] tgt
);
  localparam int RSV = DW - CW - 1;

  ctl_t ctl_q;
  logic written_q;
  logic unused_wr_bits;

  assign unused_wr_bits = ^wr_data[DW-1:CW];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '{dir: 1'b1, pre: 2'b00, src: 2'b00, en: 1'b1};
      written_q <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (wr_en) begin
        ctl_q     <= ctl_t'(wr_data[CW-1:0]);
        written_q <= 1'b1;
      end
      rd_data <= {{RSV{1'b0}}, busy, ctl_q};
    end
  end

  assign tgt = pick(written_q, ctl_q);

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en ##1 !wr_en) |=> (rd_data[CW-1:0] == $past(wr_data[CW-1:0], 2)));

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[DW-1:CW+1] == '0);

  // R1
  force_xtal_chk: assert property (@(posedge clk) disable iff (rst)
    !written_q |-> (tgt == NSRC'(1) << SRC_XTAL));

  // R6
  gated_off_chk: assert property (@(posedge clk) disable iff (rst)
    (written_q && !ctl_q.en) |-> (tgt == '0));

  // R7
  busy_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt != $past(tgt)) |=> rd_data[CW]);
endmodule

// File: rtl/clksel_top.sv
`timescale 1ns/1ps
module clksel_top
  import clksel_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          bus_clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          clk_xtal,
  input  logic          clk_src_a,
  input  logic          clk_src_b,
  input  logic          clk_obs,
  input  logic          clk_pin,
  input  logic          clk_vid,
  output logic          clk_out
);
  logic [NSRC-1:0] tgt;
  logic [NSRC-1:0] gate;
  logic [NSRC-1:0] gate_s;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] clk_vec;
  logic            busy;

  assign clk_vec = {clk_vid, clk_pin, clk_obs, clk_src_b, clk_src_a, clk_xtal};

  clksel_regs #(.DW(DW)) u_regs (
    .clk(bus_clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .busy(busy), .rd_data(rd_data), .tgt(tgt)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_lane
    // a lane may ask to open only while every other gate is shut
    assign req[i] = tgt[i] & ~|(gate & ~(NSRC'(1) << i));
    clksel_lane #(.DEPTH(DEPTH)) u_lane (
      .src_clk(clk_vec[i]), .rst(rst), .req(req[i]), .gate(gate[i])
    );
  end

  clksel_sync #(.W(NSRC), .DEPTH(DEPTH)) u_gsync (
    .clk(bus_clk), .rst(rst), .d(gate), .q(gate_s)
  );

  assign busy    = (gate_s != tgt);
  assign clk_out = |(clk_vec & gate);

  // R8
  one_gate_chk: assert property (@(posedge bus_clk) disable iff (rst)
    $onehot0(gate_s));
endmodule

// File: tb/tb_clksel_top.sv
`timescale 1ns/1ps
module tb_clksel_top;
  logic       bus_clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic clk_xtal = 0, clk_src_a = 0, clk_src_b = 0, clk_obs = 0, clk_pin = 0, clk_vid = 0;
  logic clk_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4    bus_clk   = ~bus_clk;
  always #18.5 clk_xtal  = ~clk_xtal;
  always #6.5  clk_src_a = ~clk_src_a;
  always #8.5  clk_src_b = ~clk_src_b;
  always #11.5 clk_obs   = ~clk_obs;
  always #14.5 clk_pin   = ~clk_pin;
  always #15.5 clk_vid   = ~clk_vid;

  clksel_top dut (
    .bus_clk(bus_clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .clk_xtal(clk_xtal), .clk_src_a(clk_src_a), .clk_src_b(clk_src_b),
    .clk_obs(clk_obs), .clk_pin(clk_pin), .clk_vid(clk_vid), .clk_out(clk_out)
  );

  // index -1: no clock; 0 xtal, 1 A, 2 B, 3 obs, 4 pin, 5 vid
  function automatic int expect_src(input logic [5:0] f);
    if (!f[0]) return -1;
    if (f[5]) return 5;
    if (f[2:1] == 2'b00) return 0;
    if (f[2:1] == 2'b11) return 4;
    if (f[4:3] == 2'b00) return 1;
    if (f[4:3] == 2'b10) return 2;
    if (f[4:3] == 2'b11) return 3;
    return -1;
  endfunction

  function automatic real half_per(input int s);
    case (s)
      0: return 18.5;
      1: return 6.5;
      2: return 8.5;
      3: return 11.5;
      4: return 14.5;
      5: return 15.5;
      default: return 1.0e9;
    endcase
  endfunction

  realtime last_edge = 0, last_rise = 0, prev_rise = 0;
  real     allow = 6.45;
  bit      mon = 0;
  int      viol = 0;

  always @(clk_out) begin
    if (mon && ($realtime - last_edge) < allow) viol++;
    last_edge = $realtime;
    if (clk_out) begin
      prev_rise = last_rise;
      last_rise = $realtime;
    end
  end

  task automatic check(input bit ok, input string req, input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_settle(input string req);
    int n = 0;
    while (rd_data[6] && n < 600) begin
      @(negedge bus_clk);
      n++;
    end
    check(n < 600, req, real'(n), 0.0);
  endtask

  task automatic check_clock(input int s, input string req);
    #300;
    if (s < 0) begin
      check(clk_out == 1'b0 && ($realtime - last_edge) > 250.0, req,
            $realtime - last_edge, 250.0);
    end else begin
      real per;
      per = last_rise - prev_rise;
      check(per > 2.0 * half_per(s) - 0.2 && per < 2.0 * half_per(s) + 0.2 &&
            ($realtime - last_rise) < 2.0 * half_per(s) + 0.1, req, per, 2.0 * half_per(s));
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cur;
    repeat (12) @(negedge bus_clk);
    rst = 1'b0;
    mon = 1'b1;
    @(negedge bus_clk);
    @(negedge bus_clk);
    // R1: reset field values
    check(rd_data[5:0] == 6'b100001, "R1", real'(rd_data[5:0]), 33.0);
    check(rd_data[7] == 1'b0, "R2", real'(rd_data[7]), 0.0);
    wait_settle("R1");
    // R1: crystal forced although dir=1 would pick video
    check_clock(0, "R1");
    cur = 0;

    for (int v = 0; v < 64; v++) begin
      logic [7:0] d;
      int nxt;
      string tag;
      d = {v[0], 1'b0, v[5:0]};
      nxt = expect_src(v[5:0]);
      if (!v[0]) tag = "R6";
      else if (v[5]) tag = "R5";
      else if (v[2:1] == 2'b00 || v[2:1] == 2'b11) tag = "R3";
      else tag = "R4";
      allow = ((half_per(cur) < half_per(nxt)) ? half_per(cur) : half_per(nxt)) - 0.05;
      viol = 0;
      write_reg(d);
      @(negedge bus_clk);
      // R2: read-back and reserved bit
      check(rd_data[5:0] == v[5:0], "R2", real'(rd_data[5:0]), real'(v[5:0]));
      check(rd_data[7] == 1'b0, "R2", real'(rd_data[7]), 0.0);
      // R7: busy raised for a real change
      if (nxt != cur) check(rd_data[6] == 1'b1, "R7", real'(rd_data[6]), 1.0);
      wait_settle("R7");
      check_clock(nxt, tag);
      // R8: no short pulse across the switch
      check(viol == 0, "R8", real'(viol), 0.0);
      // R7: busy stays low once settled
      check(rd_data[6] == 1'b0, "R7", real'(rd_data[6]), 0.0);
      cur = nxt;
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule